// File: doc/BRIEF.md
# Video Timing Mode Selection Controller

This block is the mode-selection controller that sits in front of a video clock and timing generator. It watches four things. The first is a 6-bit standard-select pin group. The second is a 3-bit audio-rate select pin group. The third is a lock-request pin. The fourth is a reference-present flag, together with the format index detected on the incoming reference. From these it chooses an operating mode and the format index that the downstream PLL and timing counters should produce. It keeps choosing them for as long as it runs, so the pins can be changed at any time after start-up.

The select pins are asynchronous to the block clock. They pass through a two-flop synchronizer and a stability filter before they are acted upon. Three select codes have fixed meanings:
- Codes 1 to 51 pick a preset format.
- Code 62 asks for host-programmed custom timing.
- Code 63 asks the block to follow whatever format the reference carries.
All other codes are treated as reserved.

In custom mode the block watches host register writes. It reports the default timing until the whole timing register group has been written. It flags that the output clock is still at its default rate until the whole clock register group has been written.

Every change of mode or format produces a one-cycle restart pulse, so that the downstream counters can realign. All pins are plain level signals; there is no streaming data path and therefore no handshake.

Top module: `vid_mode_ctrl`

## Requirements
- R1: While reset is held, `op_mode` is 0 and `fmt_idx`, `clk_dflt`, `aud_en`, `aud_rate` and `restart` are all 0. The `op_mode` codes are 0 = waiting, 1 = free-run, 2 = genlock, 3 = custom and 4 = follow-reference.
- R2: With a preset code (1 to 51) on `std_sel` and `lock_req` high, `op_mode` is 1 and `fmt_idx` equals the code.
- R3: With a preset code on `std_sel`, `lock_req` low and `ref_ok` high, `op_mode` is 2 and `fmt_idx` equals the code.
- R4: With a preset code on `std_sel`, `lock_req` low and `ref_ok` low, `op_mode` is 0 and `fmt_idx` is 0 (the internal default format).
- R5: With code 62 on `std_sel`, `op_mode` is 3. `fmt_idx` stays 0 until every address from 0x4E to 0x55 has been written through `wr_en`/`wr_addr` since reset, and is 62 from then on. A written address stays recorded until reset.
- R6: `clk_dflt` is 1 in custom mode until every address from 0x20 to 0x23 has been written since reset, and is 0 after that. `clk_dflt` is 0 in every other mode.
- R7: With code 63 on `std_sel` and `ref_ok` low, `op_mode` is 0 and `fmt_idx` is 0. With `ref_ok` high, `fmt_idx` is `ref_fmt` when that value lies in 1 to 51 and 0 otherwise. `op_mode` is then 2 if `lock_req` is low and 4 if it is high.
- R8: Codes 0 and 52 to 61 on `std_sel` are reserved and give `op_mode` 1 with `fmt_idx` 0.
- R9: For `aud_sel` codes 0 to 6, `aud_en` is 1 and `aud_rate` equals the code. Code 7 turns audio clock generation off: `aud_en` is 0 and `aud_rate` is 0.
- R10: A new value on the pin group {`std_sel`, `lock_req`, `aud_sel`} takes effect only after it has stayed unchanged for 4 clocks past the 2-flop synchronizer. The outputs therefore do not move within 4 clocks of a pin change, and a change lasting 2 clocks is ignored.
- R11: `restart` is high for exactly one cycle each time `op_mode` or `fmt_idx` takes a new value, in the same cycle as the new value, and is low otherwise.
- R12: The pins are re-evaluated continuously in every mode. A stable change made long after start-up still moves the outputs to the values given by R2 to R9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| std_sel | input | 6 | Standard-select pins (asynchronous) |
| lock_req | input | 1 | Lock-request pin; high forces free-run (asynchronous) |
| aud_sel | input | 3 | Audio-rate select pins (asynchronous) |
| ref_ok | input | 1 | A valid reference is present (block clock domain) |
| ref_fmt | input | 6 | Format index detected on the reference |
| wr_en | input | 1 | Host register write strobe |
| wr_addr | input | 8 | Host register write address |
| op_mode | output | 3 | Operating mode code |
| fmt_idx | output | 6 | Active format index (0 = internal default) |
| clk_dflt | output | 1 | Custom mode with the output clock still at its default rate |
| aud_en | output | 1 | Audio clock generation enabled |
| aud_rate | output | 3 | Selected base audio rate code |
| restart | output | 1 | One-cycle pulse on a change of mode or format |

## Verification
The bench sweeps `std_sel` over preset, custom, follow and reserved codes while toggling `lock_req` and `ref_ok`. This separates the free-run, genlock, waiting and follow decisions, which share the same format path.

`ref_fmt` values outside the preset range are included. They show whether the follow path falls back to the default format or passes the value through unchecked.

Random host writes inside and outside both register groups show that a group counts as written only when it is complete. Writes that miss a group are seen to have no effect.

Pin glitches two clocks long, and checks four clocks after a real change, tell a working stability filter apart from one that is too short or missing.

// File: rtl/vmc_pkg.sv
package vmc_pkg;
  localparam int SEL_W = 6;
  localparam int AUD_W = 3;

  typedef enum logic [2:0] {
    MODE_WAIT   = 3'd0,
    MODE_FREE   = 3'd1,
    MODE_LOCK   = 3'd2,
    MODE_CUSTOM = 3'd3,
    MODE_FOLLOW = 3'd4
  } mode_e;

  localparam logic [SEL_W-1:0] PRESET_LO   = 6'd1;
  localparam logic [SEL_W-1:0] PRESET_HI   = 6'd51;
  localparam logic [SEL_W-1:0] CODE_CUSTOM = 6'd62;
  localparam logic [SEL_W-1:0] CODE_FOLLOW = 6'd63;
  localparam logic [SEL_W-1:0] FMT_DEFAULT = 6'd0;
  localparam logic [AUD_W-1:0] AUD_OFF     = 3'd7;
endpackage

// File: rtl/vmc_pin_filter.sv
module vmc_pin_filter #(
  parameter int W      = 10,
  parameter int STABLE = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  localparam int CNT_W = $clog2(STABLE + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STABLE - 1);

  logic [W-1:0]     meta_q, sync_q, cand_q, filt_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      cand_q <= '0;
      filt_q <= '0;
      cnt_q  <= '0;
    end else begin
      meta_q <= din;
      sync_q <= meta_q;
      if (sync_q != cand_q) begin
        cand_q <= sync_q;
        cnt_q  <= '0;
      end else if (cnt_q != CNT_LAST) begin
        cnt_q <= cnt_q + 1'b1;
      end else begin
        filt_q <= cand_q;
      end
    end
  end

  assign dout = filt_q;

  // R10: a filtered value must have been held by the candidate for the two prior cycles
  a_r10_filter_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_q != $past(filt_q)) |-> ($past(cand_q) == filt_q && $past(cand_q, 2) == filt_q));
endmodule

// File: rtl/vmc_reg_track.sv
module vmc_reg_track #(
  parameter int ADDR_W = 8,
  parameter int BASE   = 32'h4E,
  parameter int COUNT  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic              all_done
);
  logic [COUNT-1:0] seen_q;

  for (genvar i = 0; i < COUNT; i++) begin : g_addr
    localparam logic [ADDR_W-1:0] ADDR_I = ADDR_W'(BASE + i);
    always_ff @(posedge clk) begin
      if (!rst_n)
        seen_q[i] <= 1'b0;
      else if (wr_en && wr_addr == ADDR_I)
        seen_q[i] <= 1'b1;
    end
  end

  assign all_done = &seen_q;

  // R5/R6: a completed group stays complete until reset
  a_r5_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    all_done |=> all_done);
endmodule

// File: rtl/vmc_mode_decide.sv
module vmc_mode_decide
  import vmc_pkg::*;
(
  input  logic [SEL_W-1:0] sel,
  input  logic             lock_pin,
  input  logic [AUD_W-1:0] aud,
  input  logic             ref_ok,
  input  logic [SEL_W-1:0] ref_fmt,
  input  logic             tim_done,
  input  logic             clk_done,
  output mode_e            nxt_mode,
  output logic [SEL_W-1:0] nxt_fmt,
  output logic             nxt_clkd,
  output logic             nxt_aud_en,
  output logic [AUD_W-1:0] nxt_rate
);
  logic sel_preset, ref_preset;

  assign sel_preset = (sel >= PRESET_LO) && (sel <= PRESET_HI);
  assign ref_preset = (ref_fmt >= PRESET_LO) && (ref_fmt <= PRESET_HI);

  always_comb begin
    nxt_mode = MODE_FREE;
    nxt_fmt  = FMT_DEFAULT;
    nxt_clkd = 1'b0;
    if (sel_preset) begin
      if (lock_pin) begin
        nxt_mode = MODE_FREE;
        nxt_fmt  = sel;
      end else if (ref_ok) begin
        nxt_mode = MODE_LOCK;
        nxt_fmt  = sel;
      end else begin
        nxt_mode = MODE_WAIT;
      end
    end else if (sel == CODE_CUSTOM) begin
      nxt_mode = MODE_CUSTOM;
      nxt_fmt  = tim_done ? CODE_CUSTOM : FMT_DEFAULT;
      nxt_clkd = !clk_done;
    end else if (sel == CODE_FOLLOW) begin
      if (!ref_ok) begin
        nxt_mode = MODE_WAIT;
      end else begin
        nxt_mode = lock_pin ? MODE_FOLLOW : MODE_LOCK;
        nxt_fmt  = ref_preset ? ref_fmt : FMT_DEFAULT;
      end
    end
  end

  assign nxt_aud_en = (aud != AUD_OFF);
  assign nxt_rate   = nxt_aud_en ? aud : '0;
endmodule

// File: rtl/vid_mode_ctrl.sv
module vid_mode_ctrl
  import vmc_pkg::*;
#(
  parameter int STABLE_CYC = 4,
  parameter int ADDR_W     = 8,
  parameter int TIM_BASE   = 32'h4E,
  parameter int TIM_COUNT  = 8,
  parameter int CLK_BASE   = 32'h20,
  parameter int CLK_COUNT  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [5:0]        std_sel,
  input  logic              lock_req,
  input  logic [2:0]        aud_sel,
  input  logic              ref_ok,
  input  logic [5:0]        ref_fmt,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic [2:0]        op_mode,
  output logic [5:0]        fmt_idx,
  output logic              clk_dflt,
  output logic              aud_en,
  output logic [2:0]        aud_rate,
  output logic              restart
);
  localparam int PIN_W = SEL_W + 1 + AUD_W;

  logic [PIN_W-1:0] pins_raw, pins_f;
  logic [SEL_W-1:0] sel_f;
  logic             lock_f;
  logic [AUD_W-1:0] aud_f;
  logic             tim_done, clk_done;

  mode_e            nxt_mode, mode_q;
  logic [SEL_W-1:0] nxt_fmt, fmt_q;
  logic             nxt_clkd, nxt_aud_en;
  logic [AUD_W-1:0] nxt_rate;
  logic             clkd_q, aud_en_q, restart_q;
  logic [AUD_W-1:0] rate_q;

  assign pins_raw = {std_sel, lock_req, aud_sel};

  vmc_pin_filter #(.W(PIN_W), .STABLE(STABLE_CYC)) u_filter (
    .clk(clk), .rst_n(rst_n), .din(pins_raw), .dout(pins_f)
  );

  assign {sel_f, lock_f, aud_f} = pins_f;

  vmc_reg_track #(.ADDR_W(ADDR_W), .BASE(TIM_BASE), .COUNT(TIM_COUNT)) u_tim_track (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .all_done(tim_done)
  );

  vmc_reg_track #(.ADDR_W(ADDR_W), .BASE(CLK_BASE), .COUNT(CLK_COUNT)) u_clk_track (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .all_done(clk_done)
  );

  vmc_mode_decide u_decide (
    .sel(sel_f), .lock_pin(lock_f), .aud(aud_f),
    .ref_ok(ref_ok), .ref_fmt(ref_fmt),
    .tim_done(tim_done), .clk_done(clk_done),
    .nxt_mode(nxt_mode), .nxt_fmt(nxt_fmt), .nxt_clkd(nxt_clkd),
    .nxt_aud_en(nxt_aud_en), .nxt_rate(nxt_rate)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q    <= MODE_WAIT;
      fmt_q     <= FMT_DEFAULT;
      clkd_q    <= 1'b0;
      aud_en_q  <= 1'b0;
      rate_q    <= '0;
      restart_q <= 1'b0;
    end else begin
      mode_q    <= nxt_mode;
      fmt_q     <= nxt_fmt;
      clkd_q    <= nxt_clkd;
      aud_en_q  <= nxt_aud_en;
      rate_q    <= nxt_rate;
      restart_q <= (nxt_mode != mode_q) || (nxt_fmt != fmt_q);
    end
  end

  assign op_mode  = mode_q;
  assign fmt_idx  = fmt_q;
  assign clk_dflt = clkd_q;
  assign aud_en   = aud_en_q;
  assign aud_rate = rate_q;
  assign restart  = restart_q;

  // R11: a change in mode or format is always marked by the pulse
  a_r11_change_pulses: assert property (@(posedge clk) disable iff (!rst_n)
    (op_mode != $past(op_mode) || fmt_idx != $past(fmt_idx)) |-> restart);
  // R11: the pulse never appears without a change
  a_r11_no_idle_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    restart |-> (op_mode != $past(op_mode) || fmt_idx != $past(fmt_idx)));
  // R6: clock-default flag only in custom mode
  a_r6_clkd_custom: assert property (@(posedge clk) disable iff (!rst_n)
    clk_dflt |-> (op_mode == 3'd3));
  // R9: a disabled audio clock reports rate zero
  a_r9_aud_off_rate: assert property (@(posedge clk) disable iff (!rst_n)
    !aud_en |-> (aud_rate == 3'd0));
  // R5/R8: format index is default, a preset, or the custom code
  a_r8_fmt_range: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt_idx <= 6'd51) || (fmt_idx == 6'd62));
endmodule

// File: tb/vid_mode_ctrl_bench.sv
module vid_mode_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] std_sel = '0;
  logic       lock_req = 1'b0;
  logic [2:0] aud_sel = '0;
  logic       ref_ok = 1'b0;
  logic [5:0] ref_fmt = '0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_addr = '0;
  logic [2:0] op_mode;
  logic [5:0] fmt_idx;
  logic       clk_dflt, aud_en, restart;
  logic [2:0] aud_rate;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // model state
  logic [5:0] m_sel = '0;
  logic       m_lock = 1'b0;
  logic [2:0] m_aud = '0;
  logic       m_rok = 1'b0;
  logic [5:0] m_rfmt = '0;
  logic [7:0] tim_mask = '0;
  logic [3:0] clk_mask = '0;

  always #2.5 clk = ~clk;

  vid_mode_ctrl u_vid_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .std_sel(std_sel), .lock_req(lock_req),
    .aud_sel(aud_sel), .ref_ok(ref_ok), .ref_fmt(ref_fmt),
    .wr_en(wr_en), .wr_addr(wr_addr), .op_mode(op_mode), .fmt_idx(fmt_idx),
    .clk_dflt(clk_dflt), .aud_en(aud_en), .aud_rate(aud_rate), .restart(restart)
  );

  function automatic bit is_preset(input logic [5:0] v);
    return (v >= 6'd1) && (v <= 6'd51);
  endfunction

  function automatic logic [2:0] exp_mode();
    if (is_preset(m_sel)) return m_lock ? 3'd1 : (m_rok ? 3'd2 : 3'd0);
    if (m_sel == 6'd62) return 3'd3;
    if (m_sel == 6'd63) return !m_rok ? 3'd0 : (m_lock ? 3'd4 : 3'd2);
    return 3'd1;
  endfunction

  function automatic logic [5:0] exp_fmt();
    if (is_preset(m_sel)) return (m_lock || m_rok) ? m_sel : 6'd0;
    if (m_sel == 6'd62) return (&tim_mask) ? 6'd62 : 6'd0;
    if (m_sel == 6'd63) return (m_rok && is_preset(m_rfmt)) ? m_rfmt : 6'd0;
    return 6'd0;
  endfunction

  function automatic bit exp_clkd();
    return (m_sel == 6'd62) && !(&clk_mask);
  endfunction

  function automatic string req_tag();
    if (is_preset(m_sel)) return m_lock ? "R2" : (m_rok ? "R3" : "R4");
    if (m_sel == 6'd62) return "R5";
    if (m_sel == 6'd63) return "R7";
    return "R8";
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_state();
    chk(op_mode == exp_mode(), req_tag(), "op_mode", op_mode, exp_mode());
    chk(fmt_idx == exp_fmt(), req_tag(), "fmt_idx", fmt_idx, exp_fmt());
    chk(clk_dflt == exp_clkd(), "R6", "clk_dflt", clk_dflt, exp_clkd());
    chk(aud_en == (m_aud != 3'd7), "R9", "aud_en", aud_en, m_aud != 3'd7);
    chk(aud_rate == ((m_aud != 3'd7) ? m_aud : 3'd0), "R9", "aud_rate",
        aud_rate, (m_aud != 3'd7) ? m_aud : 3'd0);
  endtask

  // Wait out a settle window; count restart pulses; optionally check R10 latency.
  task automatic settle(input bit pin_step, input logic [2:0] old_m, input logic [5:0] old_f);
    int pulses = 0;
    logic [2:0] om = op_mode;
    logic [5:0] of = fmt_idx;
    for (int i = 1; i <= 12; i++) begin
      @(negedge clk);
      if (restart) pulses++;
      if (pin_step && i == 4) begin
        chk(op_mode == om, "R10", "op_mode moved early", op_mode, om);
        chk(fmt_idx == of, "R10", "fmt_idx moved early", fmt_idx, of);
      end
    end
    check_state();
    chk(pulses == (((exp_mode() != old_m) || (exp_fmt() != old_f)) ? 1 : 0),
        "R11", "restart pulses", pulses,
        ((exp_mode() != old_m) || (exp_fmt() != old_f)) ? 1 : 0);
  endtask

  task automatic set_pins(input logic [5:0] s, input logic l, input logic [2:0] a);
    logic [2:0] pm = exp_mode();
    logic [5:0] pf = exp_fmt();
    std_sel = s; lock_req = l; aud_sel = a;
    m_sel = s; m_lock = l; m_aud = a;
    settle(1'b1, pm, pf);
  endtask

  task automatic set_ref(input logic ok, input logic [5:0] f);
    logic [2:0] pm = exp_mode();
    logic [5:0] pf = exp_fmt();
    ref_ok = ok; ref_fmt = f;
    m_rok = ok; m_rfmt = f;
    settle(1'b0, pm, pf);
  endtask

  task automatic host_wr(input logic [7:0] a);
    logic [2:0] pm = exp_mode();
    logic [5:0] pf = exp_fmt();
    wr_en = 1'b1; wr_addr = a;
    if (a >= 8'h4E && a <= 8'h55) tim_mask[a - 8'h4E] = 1'b1;
    if (a >= 8'h20 && a <= 8'h23) clk_mask[a - 8'h20] = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    settle(1'b0, pm, pf);
  endtask

  task automatic glitch(input logic [5:0] s);
    logic [2:0] pm = exp_mode();
    logic [5:0] pf = exp_fmt();
    std_sel = s;
    repeat (2) @(negedge clk);
    std_sel = m_sel;
    settle(1'b0, pm, pf);   // R10: model unchanged, expect no pulse
  endtask

  function automatic logic [5:0] pick_sel();
    int r = $urandom % 8;
    case (r)
      0, 1, 2: return 6'($urandom % 51 + 1);
      3:       return 6'd62;
      4:       return 6'd63;
      5:       return ($urandom % 2) ? 6'd0 : 6'($urandom % 10 + 52);
      default: return 6'($urandom % 64);
    endcase
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : stim
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(op_mode == 3'd0, "R1", "op_mode", op_mode, 0);
    chk(fmt_idx == 6'd0, "R1", "fmt_idx", fmt_idx, 0);
    chk(clk_dflt == 1'b0, "R1", "clk_dflt", clk_dflt, 0);
    chk(aud_en == 1'b0, "R1", "aud_en", aud_en, 0);
    chk(aud_rate == 3'd0, "R1", "aud_rate", aud_rate, 0);
    chk(restart == 1'b0, "R1", "restart", restart, 0);
    rst_n = 1'b1;
    repeat (12) @(negedge clk);
    check_state();                       // R8: code 0 reserved after start-up

    set_pins(6'd10, 1'b1, 3'd2);         // R2
    set_pins(6'd10, 1'b0, 3'd2);         // R4
    set_ref(1'b1, 6'd20);                // R3
    glitch(6'd30);                       // R10 glitch ignored
    set_pins(6'd57, 1'b0, 3'd7);         // R8 and R9 audio off
    set_pins(6'd63, 1'b0, 3'd5);         // R7 genlock on reference
    set_pins(6'd63, 1'b1, 3'd5);         // R7 follow
    set_ref(1'b1, 6'd55);                // R7 out-of-range reference
    set_ref(1'b0, 6'd55);                // R7 waiting
    set_pins(6'd62, 1'b0, 3'd1);         // R5 default before writes
    host_wr(8'h56);                      // outside both groups
    for (int a = 8'h4E; a <= 8'h54; a++) host_wr(8'(a));  // R5 partial
    host_wr(8'h55);                      // R5 complete
    host_wr(8'h20); host_wr(8'h21); host_wr(8'h22);       // R6 partial
    host_wr(8'h23);                      // R6 complete

    for (int n = 0; n < 150; n++) begin  // R12 continuous re-evaluation
      int k = $urandom % 4;
      if (k <= 1) set_pins(pick_sel(), 1'($urandom % 2), 3'($urandom % 8));
      else if (k == 2) set_ref(1'($urandom % 2), 6'($urandom % 64));
      else if ($urandom % 3 == 0) glitch(6'($urandom % 64));
      else host_wr(8'($urandom % 60 + 8'h1C));
    end
    set_pins(6'd5, 1'b1, 3'd0);          // R12 late change still applied
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule